// File: doc/BRIEF.md
# Hardware Loop Sequencer for a Branch-Free Fetch Unit

This block produces the address of the next instruction for a processor whose programs contain no data-dependent branches. Loops are the only way control leaves straight-line order. A loop-begin instruction hands the block three fields: the address where the body starts, the address of the body's last instruction, and the number of passes. The block keeps these fields as an entry on a small hardware stack, so loops can nest.

On every fetch the block compares the fetched address with the last-instruction address of the innermost active loop. If they match and passes remain, the next address is the body start and the pass count drops by one. If the last pass has finished, the entry is removed and the same address is then checked against the next enclosing loop. Loops that share a last instruction therefore all resolve in one fetch. Otherwise the next address is the current one plus one 16-bit instruction (2 bytes). Because all of this depends only on stored loop state, the next address is always known in the same cycle. It never has to be guessed.

A loop-begin with zero passes jumps over the body. A loop-begin that arrives when the stack is full is discarded, and a sticky error flag is raised. Occupancy is tracked by a three-state machine: EMPTY (no entries), ACTIVE (some entries, room left) and FULL. Its transitions are LOAD (EMPTY to ACTIVE on a push), FILL (ACTIVE to FULL when a push takes the last slot), DRAIN (ACTIVE to EMPTY when the last entries are popped), RELEASE (FULL to ACTIVE when some entries are popped) and FLUSH (FULL to EMPTY when a shared loop end pops every entry). With a one-entry stack, a push moves EMPTY straight to FULL.

Top module: `loop_seq_ctrl`

## Requirements
- R1: After reset the stack is empty and `overflow_err` is 0. While the stack is empty, a fetch without a push gives `next_pc = pc + 2`.
- R2: While `fetch_valid` is 0, `next_pc` equals `pc`, and neither the stack nor `overflow_err` changes.
- R3: A fetch with `push_valid` = 1, `push_count` > 0 and a stack that is not full places a new innermost entry {`push_start`, `push_end`, `push_count`} on the stack and gives `next_pc = pc + 2`.
- R4: A fetch without a push, whose `pc` equals the innermost entry's end address while that entry's count is greater than 1, gives `next_pc` = that entry's start address and lowers its count by 1.
- R5: A fetch without a push, whose `pc` equals the innermost entry's end address while that entry's count is 1, removes the entry. If no enclosing loop matches, `next_pc = pc + 2`.
- R6: After an entry is removed under R5, the same `pc` is checked against the next enclosing entry in the same cycle, following the rules of R4 and R5. Any number of loops sharing one end address resolve in a single fetch.
- R7: A push with `push_count` = 0 gives `next_pc = push_end + 2` and leaves the stack unchanged.
- R8: A push with `push_count` > 0 while the stack holds DEPTH (default 4) entries is discarded. It sets `overflow_err`, which stays 1 until reset. The fetch still gives `next_pc = pc + 2`.
- R9: Only the innermost entry is compared with `pc`. A `pc` that matches only an enclosing loop's end gives `pc + 2` and changes nothing.
- R10: On a fetch carrying a push, no end-address check is made. A `pc` equal to the innermost end address gives `pc + 2` (or the skip target of R7), and that entry's count is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch of `pc` happens this cycle |
| pc | input | AW (16) | Byte address of the instruction being fetched |
| push_valid | input | 1 | The fetched instruction is a loop-begin |
| push_start | input | AW (16) | Address of the first instruction of the loop body |
| push_end | input | AW (16) | Address of the last instruction of the loop body |
| push_count | input | CW (8) | Number of passes through the body; 0 skips the body |
| next_pc | output | AW (16) | Address of the next instruction to fetch |
| overflow_err | output | 1 | Sticky flag: a push was discarded because the stack was full |

## Verification
`next_pc` is combinational: it is due in the same cycle as the fetch that causes it. The stack contents and `overflow_err` change only at the following rising edge, so an overflow caused by one fetch is first visible during the next fetch. The bench drives each fetch just after a falling edge and samples `next_pc` 1 ns later, before the rising edge. It compares `overflow_err` with the flag value the reference model held before that fetch, and only then advances the model to its post-edge state. A closed-loop run feeds each `next_pc` back as the next `pc`, so nested loops with a shared end address are exercised in the order a real program would produce.

// File: rtl/loop_stack_pkg.sv
package loop_stack_pkg;

    // Occupancy of the loop stack
    typedef enum logic [1:0] {
        LS_EMPTY  = 2'd0,
        LS_ACTIVE = 2'd1,
        LS_FULL   = 2'd2
    } ls_state_e;

    // What the current fetch does to the sequencer
    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_SKIP   = 3'd1,
        OP_PUSH   = 3'd2,
        OP_REJECT = 3'd3,
        OP_STEP   = 3'd4
    } fetch_op_e;

endpackage

// File: rtl/loop_entry_file.sv
module loop_entry_file #(
    parameter int AW    = 16,
    parameter int CW    = 8,
    parameter int DEPTH = 4,
    parameter int PTRW  = 3,
    parameter int IW    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_en,
    input  logic [PTRW-1:0]           push_idx,
    input  logic [AW-1:0]             push_start,
    input  logic [AW-1:0]             push_end,
    input  logic [CW-1:0]             push_count,
    input  logic                      dec_en,
    input  logic [IW-1:0]             dec_idx,
    output logic [DEPTH-1:0][AW-1:0]  start_arr,
    output logic [DEPTH-1:0][AW-1:0]  end_arr,
    output logic [DEPTH-1:0][CW-1:0]  count_arr
);

    // One slot per nesting level; a slot is written by a push or
    // has its pass count lowered by a loop-back.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                start_arr[g] <= '0;
                end_arr[g]   <= '0;
                count_arr[g] <= '0;
            end else if (push_en && (push_idx == PTRW'(g))) begin
                start_arr[g] <= push_start;
                end_arr[g]   <= push_end;
                count_arr[g] <= push_count;
            end else if (dec_en && (dec_idx == IW'(g))) begin
                count_arr[g] <= count_arr[g] - CW'(1);
            end
        end
    end

endmodule

// File: rtl/loop_resolve.sv
module loop_resolve #(
    parameter int AW         = 16,
    parameter int CW         = 8,
    parameter int DEPTH      = 4,
    parameter int PTRW       = 3,
    parameter int IW         = 2,
    parameter int INSN_BYTES = 2
) (
    input  logic [AW-1:0]             pc,
    input  logic [PTRW-1:0]           depth,
    input  logic [DEPTH-1:0][AW-1:0]  start_arr,
    input  logic [DEPTH-1:0][AW-1:0]  end_arr,
    input  logic [DEPTH-1:0][CW-1:0]  count_arr,
    output logic                      redirect,
    output logic [AW-1:0]             target,
    output logic [IW-1:0]             dec_idx,
    output logic [PTRW-1:0]           pop_cnt
);

    localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

    logic searching;

    // Walk from the innermost occupied slot outward. Each slot whose
    // end matches on its last pass is popped; the first slot with
    // passes left loops back; the first mismatch stops the walk.
    always_comb begin
        redirect  = 1'b0;
        target    = pc + STEP;
        dec_idx   = '0;
        pop_cnt   = '0;
        searching = 1'b1;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (searching && (PTRW'(k) < depth)) begin
                if (end_arr[k] == pc) begin
                    if (count_arr[k] > CW'(1)) begin
                        redirect  = 1'b1;
                        target    = start_arr[k];
                        dec_idx   = IW'(k);
                        searching = 1'b0;
                    end else begin
                        pop_cnt = pop_cnt + PTRW'(1);
                    end
                end else begin
                    searching = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/loop_seq_ctrl.sv
module loop_seq_ctrl #(
    parameter int AW         = 16,
    parameter int CW         = 8,
    parameter int DEPTH      = 4,
    parameter int INSN_BYTES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    input  logic [AW-1:0] pc,
    input  logic          push_valid,
    input  logic [AW-1:0] push_start,
    input  logic [AW-1:0] push_end,
    input  logic [CW-1:0] push_count,
    output logic [AW-1:0] next_pc,
    output logic          overflow_err
);
    import loop_stack_pkg::*;

    localparam int            PTRW = $clog2(DEPTH + 1);
    localparam int            IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);
    localparam logic [PTRW-1:0] DEPTH_P = PTRW'(DEPTH);

    ls_state_e     state_q, state_nxt;
    fetch_op_e     op;
    logic [PTRW-1:0] depth_q, depth_nxt;
    logic          ovf_q, ovf_set;

    logic          push_en, dec_en;
    logic                     res_redirect;
    logic [AW-1:0]            res_target;
    logic [IW-1:0]            res_dec_idx;
    logic [PTRW-1:0]          res_pop_cnt;
    logic [DEPTH-1:0][AW-1:0] start_arr;
    logic [DEPTH-1:0][AW-1:0] end_arr;
    logic [DEPTH-1:0][CW-1:0] count_arr;

    loop_entry_file #(
        .AW(AW), .CW(CW), .DEPTH(DEPTH), .PTRW(PTRW), .IW(IW)
    ) u_entries (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_en    (push_en),
        .push_idx   (depth_q),
        .push_start (push_start),
        .push_end   (push_end),
        .push_count (push_count),
        .dec_en     (dec_en),
        .dec_idx    (res_dec_idx),
        .start_arr  (start_arr),
        .end_arr    (end_arr),
        .count_arr  (count_arr)
    );

    loop_resolve #(
        .AW(AW), .CW(CW), .DEPTH(DEPTH), .PTRW(PTRW), .IW(IW),
        .INSN_BYTES(INSN_BYTES)
    ) u_resolve (
        .pc        (pc),
        .depth     (depth_q),
        .start_arr (start_arr),
        .end_arr   (end_arr),
        .count_arr (count_arr),
        .redirect  (res_redirect),
        .target    (res_target),
        .dec_idx   (res_dec_idx),
        .pop_cnt   (res_pop_cnt)
    );

    // Classify the fetch
    always_comb begin
        if (!fetch_valid) begin
            op = OP_HOLD;
        end else if (push_valid) begin
            if (push_count == '0) begin
                op = OP_SKIP;
            end else if (state_q == LS_FULL) begin
                op = OP_REJECT;
            end else begin
                op = OP_PUSH;
            end
        end else begin
            op = OP_STEP;
        end
    end

    // Output process: next address and the commands to the stack
    always_comb begin
        next_pc   = pc;
        push_en   = 1'b0;
        dec_en    = 1'b0;
        ovf_set   = 1'b0;
        depth_nxt = depth_q;
        unique case (op)
            OP_HOLD: begin
                next_pc = pc;
            end
            OP_SKIP: begin
                next_pc = push_end + STEP;
            end
            OP_PUSH: begin
                next_pc   = pc + STEP;
                push_en   = 1'b1;
                depth_nxt = depth_q + PTRW'(1);
            end
            OP_REJECT: begin
                next_pc = pc + STEP;
                ovf_set = 1'b1;
            end
            OP_STEP: begin
                next_pc   = res_target;
                dec_en    = res_redirect;
                depth_nxt = depth_q - res_pop_cnt;
            end
            default: begin
                next_pc = pc;
            end
        endcase
    end

    // Occupancy transitions: LOAD, FILL, DRAIN, RELEASE, FLUSH
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            LS_EMPTY: begin
                if (op == OP_PUSH) begin
                    state_nxt = (depth_nxt == DEPTH_P) ? LS_FULL : LS_ACTIVE;
                end
            end
            LS_ACTIVE: begin
                if (op == OP_PUSH && depth_nxt == DEPTH_P) begin
                    state_nxt = LS_FULL;
                end else if (op == OP_STEP && depth_nxt == '0) begin
                    state_nxt = LS_EMPTY;
                end
            end
            LS_FULL: begin
                if (op == OP_STEP && res_pop_cnt != '0) begin
                    state_nxt = (depth_nxt == '0) ? LS_EMPTY : LS_ACTIVE;
                end
            end
            default: begin
                state_nxt = LS_EMPTY;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_EMPTY;
            depth_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_nxt;
            depth_q <= depth_nxt;
            if (ovf_set) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign overflow_err = ovf_q;

endmodule

// File: rtl/loop_seq_chk.sv
module loop_seq_chk #(
    parameter int AW         = 16,
    parameter int CW         = 8,
    parameter int DEPTH      = 4,
    parameter int INSN_BYTES = 2,
    parameter int PTRW       = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fetch_valid,
    input logic [AW-1:0]   pc,
    input logic            push_valid,
    input logic [AW-1:0]   push_end,
    input logic [CW-1:0]   push_count,
    input logic [AW-1:0]   next_pc,
    input logic            overflow_err,
    input logic [PTRW-1:0] depth_q,
    input logic [1:0]      state_q
);
    import loop_stack_pkg::*;

    localparam logic [AW-1:0]   STEP    = AW'(INSN_BYTES);
    localparam logic [PTRW-1:0] DEPTH_P = PTRW'(DEPTH);

    AST_HOLD_PC: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> next_pc == pc); // R2
    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> $stable(depth_q) && $stable(overflow_err)); // R2
    AST_EMPTY_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && !push_valid && depth_q == '0 |-> next_pc == pc + STEP); // R1
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && push_valid && push_count != '0 && depth_q < DEPTH_P
        |=> depth_q == $past(depth_q) + PTRW'(1)); // R3
    AST_SKIP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && push_valid && push_count == '0 |-> next_pc == push_end + STEP); // R7
    AST_SKIP_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && push_valid && push_count == '0 |=> $stable(depth_q)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err); // R8
    AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && push_valid && push_count != '0 && depth_q == DEPTH_P
        |=> overflow_err && $stable(depth_q)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= DEPTH_P); // R8
    AST_EMPTY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_q == '0) == (state_q == 2'(LS_EMPTY))); // R1

endmodule

bind loop_seq_ctrl loop_seq_chk #(
    .AW(AW), .CW(CW), .DEPTH(DEPTH), .INSN_BYTES(INSN_BYTES), .PTRW(PTRW)
) u_loop_seq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_valid  (fetch_valid),
    .pc           (pc),
    .push_valid   (push_valid),
    .push_end     (push_end),
    .push_count   (push_count),
    .next_pc      (next_pc),
    .overflow_err (overflow_err),
    .depth_q      (depth_q),
    .state_q      (state_q)
);

// File: tb/test_loop_seq_ctrl.sv
`timescale 1ns/1ps
module test_loop_seq_ctrl;
    localparam int AW = 16;
    localparam int CW = 8;
    localparam int DEPTH = 4;
    localparam int MASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] pc = '0;
    logic          push_valid = 1'b0;
    logic [AW-1:0] push_start = '0;
    logic [AW-1:0] push_end = '0;
    logic [CW-1:0] push_count = '0;
    logic [AW-1:0] next_pc;
    logic          overflow_err;

    always #2.5 clk = ~clk;

    loop_seq_ctrl #(.AW(AW), .CW(CW), .DEPTH(DEPTH), .INSN_BYTES(2)) i_loop_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .pc(pc),
        .push_valid(push_valid), .push_start(push_start), .push_end(push_end),
        .push_count(push_count), .next_pc(next_pc), .overflow_err(overflow_err)
    );

    typedef struct { int s; int e; int c; } ent_t;
    ent_t stk[$];
    bit   m_ovf;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [AW-1:0] got;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Apply one fetch, compare against the behavioural model, then advance the model
    task automatic step(string tag, bit fv, bit pv, int ps, int pe, int pcnt, int pcv,
                        output logic [AW-1:0] res);
        int  exp;
        bit  ovf_before;
        @(negedge clk);
        fetch_valid = fv; push_valid = pv;
        push_start = AW'(ps); push_end = AW'(pe); push_count = CW'(pcnt); pc = AW'(pcv);
        #1;
        ovf_before = m_ovf;
        if (!fv) begin
            exp = pcv;
        end else if (pv) begin
            if (pcnt == 0) begin
                exp = (pe + 2) & MASK;
            end else if (stk.size() == DEPTH) begin
                m_ovf = 1'b1;
                exp = (pcv + 2) & MASK;
            end else begin
                stk.push_back('{ps, pe, pcnt});
                exp = (pcv + 2) & MASK;
            end
        end else begin
            exp = (pcv + 2) & MASK;
            while (stk.size() > 0 && stk[stk.size()-1].e == pcv) begin
                if (stk[stk.size()-1].c > 1) begin
                    stk[stk.size()-1].c--;
                    exp = stk[stk.size()-1].s;
                    break;
                end
                void'(stk.pop_back());
            end
        end
        chk(tag, int'(next_pc), exp);
        chk({tag, " overflow_err"}, int'(overflow_err), int'(ovf_before));
        res = next_pc;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; push_valid = 1'b0; fetch_valid = 1'b1; pc = 16'h0100;
        stk.delete(); m_ovf = 1'b0;
        #1;
        chk("R1 reset next_pc", int'(next_pc), 16'h0102);
        chk("R1 reset overflow_err", int'(overflow_err), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Program used for the closed-loop run
    task automatic decode(int a, output bit pv, output int ps, output int pe, output int pc_n);
        pv = 1'b0; ps = 0; pe = 0; pc_n = 0;
        case (a)
            16'h0300: begin pv = 1'b1; ps = 16'h0302; pe = 16'h030A; pc_n = 3; end
            16'h0302: begin pv = 1'b1; ps = 16'h0304; pe = 16'h030A; pc_n = 2; end
            16'h0306: begin pv = 1'b1; ps = 16'h0308; pe = 16'h0308; pc_n = 0; end
            16'h030C: begin pv = 1'b1; ps = 16'h030E; pe = 16'h0310; pc_n = 2; end
            default: ;
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        step("R1 empty sequential", 1, 0, 0, 0, 0, 16'h0100, got);
        step("R2 hold without fetch", 0, 0, 0, 0, 0, 16'h0200, got);
        step("R2 hold ignores push", 0, 1, 16'h0012, 16'h0020, 5, 16'h0010, got);
        step("R3 push loop", 1, 1, 16'h0012, 16'h0020, 3, 16'h0010, got);
        step("R3 body sequential", 1, 0, 0, 0, 0, 16'h0018, got);
        step("R4 loop back pass 1", 1, 0, 0, 0, 0, 16'h0020, got);
        step("R2 idle keeps count", 0, 0, 0, 0, 0, 16'h0020, got);
        step("R4 loop back pass 2", 1, 0, 0, 0, 0, 16'h0020, got);
        step("R5 last pass pops", 1, 0, 0, 0, 0, 16'h0020, got);
        step("R5 stack now empty", 1, 0, 0, 0, 0, 16'h0020, got);

        // Shared end: inner pops, outer loops back in the same fetch
        step("R3 push outer", 1, 1, 16'h0040, 16'h0050, 2, 16'h003E, got);
        step("R3 push inner", 1, 1, 16'h0042, 16'h0050, 1, 16'h0040, got);
        step("R6 inner pop outer back", 1, 0, 0, 0, 0, 16'h0050, got);
        step("R6 outer last pass", 1, 0, 0, 0, 0, 16'h0050, got);
        // Three loops ending together on their last pass
        step("R3 push a", 1, 1, 16'h0062, 16'h0070, 1, 16'h0060, got);
        step("R3 push b", 1, 1, 16'h0064, 16'h0070, 1, 16'h0062, got);
        step("R3 push c", 1, 1, 16'h0066, 16'h0070, 1, 16'h0064, got);
        step("R6 triple pop", 1, 0, 0, 0, 0, 16'h0070, got);
        step("R6 all gone", 1, 0, 0, 0, 0, 16'h0070, got);

        // Zero-pass skip leaves the outer loop on top
        step("R3 push outer", 1, 1, 16'h0082, 16'h0090, 2, 16'h0080, got);
        step("R7 skip body", 1, 1, 16'h0086, 16'h0088, 0, 16'h0084, got);
        step("R7 outer still on top", 1, 0, 0, 0, 0, 16'h0090, got);
        step("R7 end of skip target", 1, 0, 0, 0, 0, 16'h0088, got);

        // Only the innermost end is compared
        do_reset();
        step("R3 push outer", 1, 1, 16'h00A2, 16'h00B0, 2, 16'h00A0, got);
        step("R3 push inner", 1, 1, 16'h00A4, 16'h00A8, 2, 16'h00A2, got);
        step("R9 outer end ignored", 1, 0, 0, 0, 0, 16'h00B0, got);
        step("R9 inner loops back", 1, 0, 0, 0, 0, 16'h00A8, got);
        step("R10 push at end no check", 1, 1, 16'h00C0, 16'h00C8, 1, 16'h00A8, got);
        step("R10 skip at end no check", 1, 1, 16'h00D0, 16'h00D8, 0, 16'h00C8, got);
        step("R10 end resolves after", 1, 0, 0, 0, 0, 16'h00C8, got);
        step("R10 count kept", 1, 0, 0, 0, 0, 16'h00A8, got);

        // Overflow
        do_reset();
        step("R3 fill 1", 1, 1, 16'h0402, 16'h0480, 2, 16'h0400, got);
        step("R3 fill 2", 1, 1, 16'h0404, 16'h0470, 2, 16'h0402, got);
        step("R3 fill 3", 1, 1, 16'h0406, 16'h0460, 2, 16'h0404, got);
        step("R3 fill 4", 1, 1, 16'h0408, 16'h0450, 2, 16'h0406, got);
        step("R8 push when full", 1, 1, 16'h040A, 16'h0440, 2, 16'h0408, got);
        step("R8 rejected entry absent", 1, 0, 0, 0, 0, 16'h0440, got);
        step("R8 top unchanged", 1, 0, 0, 0, 0, 16'h0450, got);
        step("R8 flag sticky", 1, 0, 0, 0, 0, 16'h0450, got);
        step("R8 flag sticky idle", 0, 0, 0, 0, 0, 16'h0460, got);
        do_reset();
        step("R1 flag cleared", 1, 0, 0, 0, 0, 16'h0500, got);

        // Closed-loop program with nested loops sharing an end
        begin
            int a = 16'h0300;
            for (int n = 0; n < 200 && a != 16'h0320; n++) begin
                bit pv; int ps; int pe; int pcn;
                decode(a, pv, ps, pe, pcn);
                step("R6 program run", 1, pv, ps, pe, pcn, a, got);
                a = int'(got);
            end
            chk("R6 program reached exit", a, 16'h0320);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule